// File: doc/BRIEF.md
# PCM Serial Audio Clock Generator

This block derives the two clocks an external audio DAC needs from a master PCM clock. The first is a bit clock with a 50% duty cycle. The second is a left/right word clock. It also produces a one-cycle frame-start strobe that a sample serializer uses to align its shift register with the left channel.

A control block supplies the settings: an even divide ratio for the bit clock, a two-bit word-length code, a polarity-invert bit and a clock-enable bit. With a 16-bit word length a frame spans 32 bit clocks. With any longer word length a frame spans 64 bit clocks. The clocks can be held stopped or released by the enable alone, whatever the decoder upstream is doing. Settings that change while the clocks run are deferred to the next frame boundary, so the DAC never sees a shortened period.

Top module: `pcm_clkgen`

## Requirements
- R1: While `rst_ni` is low, `sclk_o`, `lrclk_o` and `frame_start_o` are all 0.
- R2: After a rising master-clock edge that samples `clk_en_i` = 0, the outputs are `sclk_o` = 0 and `frame_start_o` = 0, and `lrclk_o` equals `lrclk_inv_i`.
- R3: The bit clock period is N = 2*(`div_sel_i`+1) master cycles, so N runs from 2 to 16. `sclk_o` is high for exactly half of each period.
- R4: The word-length code is 00 = 16, 01 = 18, 10 = 20 and 11 = 24 bits. Code 00 gives a frame of 32 bit-clock periods and every other code gives 64.
- R5: The word clock is at its left level for the first half of each frame's bit-clock periods and at its right level for the second half. It changes only on the edge where `sclk_o` falls.
- R6: The left level of `lrclk_o` is 0 when `lrclk_inv_i` = 0 and 1 when `lrclk_inv_i` = 1. The right level is always the opposite of the left level.
- R7: `frame_start_o` is high for exactly one master cycle at the start of each frame, and the word clock is at its left level during that cycle.
- R8: Counting edges from the edge that first samples `clk_en_i` = 1 after a stop, that edge raises `frame_start_o` and `sclk_o` rises N/2 edges later. Every run therefore restarts at the beginning of a frame.
- R9: A change to `div_sel_i`, `wlen_i` or `lrclk_inv_i` while the clocks run leaves the current frame unchanged. The new setting takes effect on the edge that starts the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master PCM clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | 1 releases the clocks, 0 stops them at idle level |
| div_sel_i | input | DIV_W | Bit-clock half period minus one, in master cycles |
| wlen_i | input | 2 | Word-length code |
| lrclk_inv_i | input | 1 | Word-clock polarity invert |
| sclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Left/right word clock |
| frame_start_o | output | 1 | One-cycle strobe at each left-channel frame start |

## Verification
A fault in the divider counter appears as a wrong `sclk_o` period within a single bit-clock period. A fault in the bit counter or the frame-length selection first shows at the next half-frame or frame edge: `lrclk_o` or `frame_start_o` arrives up to 64 bit clocks early or late. A fault in settings capture shows at the first frame boundary after a change, as a period, frame length or polarity that is wrong or applied too early. The bench predicts every output bit in every master cycle from the requirement formulas, so any of these faults is caught on the first wrong cycle.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

  typedef enum logic [1:0] {
    WLEN_16 = 2'b00,
    WLEN_18 = 2'b01,
    WLEN_20 = 2'b10,
    WLEN_24 = 2'b11
  } wlen_e;

  // Only the 16-bit word uses the short frame.
  function automatic logic wlen_is_long(input logic [1:0] code);
    return code != WLEN_16;
  endfunction

endpackage

// File: rtl/pcm_cfg_reg.sv
module pcm_cfg_reg #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       wlen_i,
  input  logic             inv_i,
  output logic [DIV_W-1:0] div_q_o,
  output logic             long_q_o,
  output logic             inv_q_o
);
  import pcm_clkgen_pkg::*;

  logic [DIV_W-1:0] div_q, div_d;
  logic             long_q, long_d;
  logic             inv_q, inv_d;

  always_comb begin
    div_d  = div_q;
    long_d = long_q;
    inv_d  = inv_q;
    if (load_i) begin
      div_d  = div_i;
      long_d = wlen_is_long(wlen_i);
      inv_d  = inv_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      long_q <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      long_q <= long_d;
      inv_q  <= inv_d;
    end
  end

  assign div_q_o  = div_q;
  assign long_q_o = long_q;
  assign inv_q_o  = inv_q;
endmodule

// File: rtl/pcm_sclk_div.sv
module pcm_sclk_div #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick = !clr_i && (cnt_q == half_i);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (clr_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = tick && sclk_q;
endmodule

// File: rtl/pcm_frame_seq.sv
module pcm_frame_seq #(
  parameter int SHORT_BITS = 32,
  parameter int LONG_BITS  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fall_i,
  input  logic long_i,
  input  logic inv_act_i,
  input  logic inv_new_i,
  output logic wrap_o,
  output logic lr_raw_o,
  output logic lrclk_o
);
  localparam int CNT_W = $clog2(LONG_BITS);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SHORT_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] HALF_S = CNT_W'(SHORT_BITS / 2);
  localparam logic [CNT_W-1:0] HALF_L = CNT_W'(LONG_BITS / 2);

  logic [CNT_W-1:0] bit_q, bit_d, last, half;
  logic             raw_q, raw_d;
  logic             lr_q, lr_d;

  assign last   = long_i ? LAST_L : LAST_S;
  assign half   = long_i ? HALF_L : HALF_S;
  assign wrap_o = fall_i && (bit_q == last);

  always_comb begin
    bit_d = bit_q;
    raw_d = raw_q;
    lr_d  = lr_q;
    if (clr_i || wrap_o) begin
      bit_d = '0;
      raw_d = 1'b0;
      lr_d  = inv_new_i;
    end else if (fall_i) begin
      bit_d = bit_q + 1'b1;
      raw_d = (bit_d >= half);
      lr_d  = raw_d ^ inv_act_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      raw_q <= 1'b0;
      lr_q  <= 1'b0;
    end else begin
      bit_q <= bit_d;
      raw_q <= raw_d;
      lr_q  <= lr_d;
    end
  end

  assign lr_raw_o = raw_q;
  assign lrclk_o  = lr_q;
endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int DIV_W      = 3,
  parameter int SHORT_BITS = 32,
  parameter int LONG_BITS  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic [1:0]       wlen_i,
  input  logic             lrclk_inv_i,
  output logic             sclk_o,
  output logic             lrclk_o,
  output logic             frame_start_o
);
  logic             run_q, run_d;
  logic             fs_q, fs_d;
  logic             start, clr, wrap, fall, load;
  logic [DIV_W-1:0] div_act;
  logic             long_act, inv_act;
  logic             lr_raw;

  assign start = clk_en_i && !run_q;
  assign clr   = !(clk_en_i && run_q);
  assign load  = clr || wrap;

  always_comb begin
    run_d = clk_en_i;
    fs_d  = start || wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      fs_q  <= fs_d;
    end
  end

  pcm_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .div_i    (div_sel_i),
    .wlen_i   (wlen_i),
    .inv_i    (lrclk_inv_i),
    .div_q_o  (div_act),
    .long_q_o (long_act),
    .inv_q_o  (inv_act)
  );

  pcm_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .half_i (div_act),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  pcm_frame_seq #(.SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .fall_i    (fall),
    .long_i    (long_act),
    .inv_act_i (inv_act),
    .inv_new_i (lrclk_inv_i),
    .wrap_o    (wrap),
    .lr_raw_o  (lr_raw),
    .lrclk_o   (lrclk_o)
  );

  assign frame_start_o = fs_q;
endmodule

// File: rtl/pcm_clkgen_chk.sv
module pcm_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_i,
  input logic sclk_o,
  input logic lrclk_o,
  input logic frame_start_o,
  input logic run_q,
  input logic lr_raw
);
  AST_IDLE_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> !sclk_o); // R2
  AST_IDLE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !lr_raw); // R2
  AST_LR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && (lrclk_o != $past(lrclk_o))) |-> (!sclk_o && $past(sclk_o))); // R5
  AST_FS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o); // R7
  AST_FS_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> !lr_raw); // R7
  AST_SCLK_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> run_q); // R8
endmodule

bind pcm_clkgen pcm_clkgen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_en_i      (clk_en_i),
  .sclk_o        (sclk_o),
  .lrclk_o       (lrclk_o),
  .frame_start_o (frame_start_o),
  .run_q         (run_q),
  .lr_raw        (lr_raw)
);

// File: tb/tb_pcm_clkgen.sv
module tb_pcm_clkgen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en_i = 1'b0;
  logic [2:0] div_sel_i = '0;
  logic [1:0] wlen_i = '0;
  logic       lrclk_inv_i = 1'b0;
  logic       sclk_o, lrclk_o, frame_start_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic  s;
    logic  l;
    logic  f;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  pcm_clkgen dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clk_en_i      (clk_en_i),
    .div_sel_i     (div_sel_i),
    .wlen_i        (wlen_i),
    .lrclk_inv_i   (lrclk_inv_i),
    .sclk_o        (sclk_o),
    .lrclk_o       (lrclk_o),
    .frame_start_o (frame_start_o)
  );

  always #10 clk_i = !clk_i;

  // Monitor: one expected item per master cycle, compared mid-cycle.
  always @(negedge clk_i) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (sclk_o !== e.s || lrclk_o !== e.l || frame_start_o !== e.f) begin
        n_fail++;
        $display("FAIL %s: sclk/lrclk/fs actual %b%b%b expected %b%b%b at %0t",
                 e.tag, sclk_o, lrclk_o, frame_start_o, e.s, e.l, e.f, $time);
      end
    end
  end

  // Expected run from the requirement formulas: t edges after the start edge.
  task automatic push_run(input int d, input int wl, input bit inv, input int n, input string tag);
    int h  = d + 1;
    int fb = (wl == 0) ? 32 : 64;
    for (int t = 0; t < n; t++) begin
      exp_t e;
      int bitn = (t / (2 * h)) % fb;
      e.s   = ((t / h) % 2) == 1;
      e.l   = (bitn >= fb / 2) ^ inv;
      e.f   = (t % (2 * h * fb)) == 0;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  task automatic idle(input bit inv, input int n, input string tag);
    @(negedge clk_i);
    clk_en_i = 1'b0;
    lrclk_inv_i = inv;
    #1;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.s = 1'b0; e.l = inv; e.f = 1'b0; e.tag = tag;
      exp_q.push_back(e);
    end
    drain();
  endtask

  task automatic start_run(input int d, input int wl, input bit inv, input int n, input string tag);
    idle(inv, 3, "R2");
    @(negedge clk_i);
    div_sel_i = 3'(d);
    wlen_i = 2'(wl);
    lrclk_inv_i = inv;
    clk_en_i = 1'b1;
    #1;
    push_run(d, wl, inv, n, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    n_tests++;
    if (sclk_o !== 1'b0 || lrclk_o !== 1'b0 || frame_start_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: outputs in reset %b%b%b expected 000", sclk_o, lrclk_o, frame_start_o);
    end
    rst_ni = 1'b1;

    idle(1'b0, 10, "R2");
    idle(1'b1, 10, "R2");

    // R3 R5 R7 R8: fastest divider, short frame
    start_run(0, 0, 1'b0, 2 * 64 + 5, "R3");
    drain();
    // R4 R6: 18-bit word, inverted, N=8
    start_run(3, 1, 1'b1, 2 * 512 + 3, "R4");
    drain();
    // R3 R4: slowest divider, 24-bit word
    start_run(7, 3, 1'b0, 1024 + 40, "R3");
    drain();
    // R4 R6: 20-bit word, N=6, inverted
    start_run(2, 2, 1'b1, 384 + 10, "R6");
    drain();

    // R8: stop mid-frame, then restart from a frame start
    start_run(1, 0, 1'b0, 50, "R8");
    drain();
    start_run(1, 0, 1'b0, 130, "R8");
    drain();

    // R9: settings change mid-frame, applied at the boundary
    start_run(1, 0, 1'b0, 128, "R9");
    push_run(0, 3, 1'b1, 140, "R9");
    repeat (20) @(negedge clk_i);
    div_sel_i = 3'd0;
    wlen_i = 2'd3;
    lrclk_inv_i = 1'b1;
    drain();

    idle(1'b0, 5, "R2");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule